// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation miss by reading one page table entry from memory and turning it into a translation or a fault. A miss request carries a virtual page number and a flag that marks the access as a store. The walker adds the zero-extended page number to a base register and reads that one word through a simple read port. The read has one request in flight and a valid strobe for the returned data. The walker then decodes the entry and returns a response that is held until the requester takes it.

The table is flat: one entry per virtual page, indexed directly by the page number. Each entry has a resident flag, a writable flag, a dirty flag and a page-number field. For a resident page the field is the physical page number. For a page that is not resident the field holds a swap location, which this block never returns. A walk ends in one of three outcomes: a translation, a page fault or a protection fault. The requester joins the returned physical page number to the untouched page offset. For example, with 256-byte pages and table entry 2 mapping to physical page 4, virtual address 0x2C8 becomes physical address 0x4C8.

The base register has its own write port. A write takes effect only while the walker is idle, so the base cannot change under a walk that is already running.

Top module: `pte_walker`

## Requirements
- R1: After reset, `miss_ready` is 1, `rsp_valid` is 0, `mem_req` is 0 and the base register holds 0.
- R2: The entry address is the base register plus the zero-extended virtual page number, modulo 2^MEM_AW. It appears on `mem_addr` with `mem_req` high for exactly one cycle, in the cycle after the miss is accepted.
- R3: Entry layout in `mem_rdata`: bit 0 is the resident flag, bit 1 is the writable flag, bit 2 is the dirty flag, and bits [PPN_W+2:3] hold the page-number field.
- R4: A resident entry that does not cause a protection fault gives `rsp_ppn` equal to the field, `rsp_writable` and `rsp_dirty` equal to the entry's flags, and both fault outputs 0. The requester forms the physical address as {rsp_ppn, offset}.
- R5: An entry with the resident flag clear gives `rsp_page_fault`=1, `rsp_prot_fault`=0 and zero on `rsp_ppn`, `rsp_writable` and `rsp_dirty`, for loads and stores alike.
- R6: A store to a resident entry whose writable flag is clear gives `rsp_prot_fault`=1, `rsp_page_fault`=0 and `rsp_ppn`=0. A load to the same entry translates normally, as in R4.
- R7: Any read latency of one or more cycles is accepted. `rsp_valid` rises in the cycle after the cycle in which `mem_rvalid` is high.
- R8: Only one walk runs at a time. `miss_ready` stays low from acceptance until the response is taken, and the response outputs stay stable while `rsp_valid` is high and `rsp_ready` is low.
- R9: A base register write made while a walk is in progress is ignored. A write made while idle is used by the next walk.
- R10: Each walk issues exactly one memory read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Translation miss request |
| miss_ready | output | 1 | Walker idle, miss accepted |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| miss_store | input | 1 | Miss is for a store access |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | MEM_AW | New table base address |
| mem_req | output | 1 | Entry read request, one cycle |
| mem_addr | output | MEM_AW | Entry word address |
| mem_rvalid | input | 1 | Entry data returned |
| mem_rdata | input | PPN_W+3 | Returned page table entry |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_ppn | output | PPN_W | Physical page number, zero on any fault |
| rsp_writable | output | 1 | Writable flag of a resident entry |
| rsp_dirty | output | 1 | Dirty flag of a resident entry |
| rsp_page_fault | output | 1 | Entry not resident |
| rsp_prot_fault | output | 1 | Store to a read-only resident page |

## Verification
The bench builds the walker with a 4-bit page number, a 3-bit physical page number and a 6-bit entry address. This makes the whole 64-word table a small array in the bench. With that array, every virtual page can be walked under several base values, including bases that wrap the address space, and the 0x2C8 to 0x4C8 example is reproduced exactly. The read latency is varied from one to six cycles and the response is stalled for up to two cycles. This exercises the wait and hold paths, and a base write lands in the middle of a long read.

// File: rtl/pwalk_pkg.sv
package pwalk_pkg;
    // Flag positions at the bottom of every table entry; the page field sits above them
    localparam int PTE_RES_BIT    = 0;
    localparam int PTE_WR_BIT     = 1;
    localparam int PTE_DIRTY_BIT  = 2;
    localparam int PTE_FLAG_BITS  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        OUT_MAPPED     = 2'd0,
        OUT_PAGE_FAULT = 2'd1,
        OUT_PROT_FAULT = 2'd2
    } walk_outcome_e;
endpackage

// File: rtl/pwalk_base_reg.sv
// Holds the table base address and forms the entry address.
// Assumes: writes are accepted only when write_ok is high (walker idle);
// the address sum wraps modulo 2^MEM_AW.
module pwalk_base_reg #(
    parameter int VPN_W  = 20,
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              write_ok,
    input  logic [MEM_AW-1:0] wr_data,
    input  logic [VPN_W-1:0]  vpn,
    output logic [MEM_AW-1:0] entry_addr
);
    logic [MEM_AW-1:0] base_q;

    // Base register: cleared by reset, loaded only when the walker is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en && write_ok) begin
            base_q <= wr_data;
        end
    end

    // Entry address: base plus zero-extended page number
    always_comb begin
        entry_addr = base_q + MEM_AW'(vpn);
    end
endmodule

// File: rtl/pwalk_pte_decode.sv
// Decodes one table entry against the access type.
// Assumes: entry layout from pwalk_pkg; purely combinational.
module pwalk_pte_decode
    import pwalk_pkg::*;
#(
    parameter int PPN_W = 20,
    localparam int PTE_W = PPN_W + PTE_FLAG_BITS
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_store,
    output logic [PPN_W-1:0] ppn,
    output logic             writable,
    output logic             dirty,
    output walk_outcome_e    outcome
);
    logic resident;

    // Outcome selection and field masking
    always_comb begin
        resident = pte[PTE_RES_BIT];
        if (!resident) begin
            outcome = OUT_PAGE_FAULT;
        end else if (is_store && !pte[PTE_WR_BIT]) begin
            outcome = OUT_PROT_FAULT;
        end else begin
            outcome = OUT_MAPPED;
        end
        ppn      = (outcome == OUT_MAPPED) ? pte[PTE_FLAG_BITS +: PPN_W] : '0;
        writable = resident & pte[PTE_WR_BIT];
        dirty    = resident & pte[PTE_DIRTY_BIT];
    end
endmodule

// File: rtl/pwalk_seq.sv
// Walk sequencer: idle, issue read, wait for data, hold response.
// Assumes: memory returns data at least one cycle after the request;
// a data strobe outside the wait state is ignored.
module pwalk_seq
    import pwalk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_valid,
    input  logic mem_rvalid,
    input  logic rsp_ready,
    output logic accept,
    output logic capture,
    output logic idle,
    output logic mem_req,
    output logic rsp_valid
);
    walk_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (miss_valid) state_d = ST_READ;
            ST_READ: state_d = ST_WAIT;
            ST_WAIT: if (mem_rvalid) state_d = ST_RESP;
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // State-decoded strobes
    always_comb begin
        idle      = (state_q == ST_IDLE);
        accept    = idle && miss_valid;
        mem_req   = (state_q == ST_READ);
        capture   = (state_q == ST_WAIT) && mem_rvalid;
        rsp_valid = (state_q == ST_RESP);
    end
endmodule

// File: rtl/pte_walker.sv
// Single-level page table walker: one entry read per translation miss.
// Assumes: flat table indexed by page number; one read outstanding;
// response is held until rsp_ready.
module pte_walker
    import pwalk_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int MEM_AW = 32,
    localparam int PTE_W = PPN_W + PTE_FLAG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic              miss_store,
    input  logic              base_we,
    input  logic [MEM_AW-1:0] base_wdata,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_writable,
    output logic              rsp_dirty,
    output logic              rsp_page_fault,
    output logic              rsp_prot_fault
);
    logic             accept, capture, idle;
    logic [VPN_W-1:0] vpn_q;
    logic             store_q;
    logic [PPN_W-1:0] dec_ppn;
    logic             dec_wr, dec_dirty;
    walk_outcome_e    dec_outcome;

    pwalk_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .mem_rvalid (mem_rvalid),
        .rsp_ready  (rsp_ready),
        .accept     (accept),
        .capture    (capture),
        .idle       (idle),
        .mem_req    (mem_req),
        .rsp_valid  (rsp_valid)
    );

    pwalk_base_reg #(.VPN_W(VPN_W), .MEM_AW(MEM_AW)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (base_we),
        .write_ok   (idle),
        .wr_data    (base_wdata),
        .vpn        (vpn_q),
        .entry_addr (mem_addr)
    );

    pwalk_pte_decode #(.PPN_W(PPN_W)) u_dec (
        .pte      (mem_rdata),
        .is_store (store_q),
        .ppn      (dec_ppn),
        .writable (dec_wr),
        .dirty    (dec_dirty),
        .outcome  (dec_outcome)
    );

    // Request capture: page number and access type held for the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            store_q <= 1'b0;
        end else if (accept) begin
            vpn_q   <= miss_vpn;
            store_q <= miss_store;
        end
    end

    // Result capture: decoded entry latched when data returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ppn        <= '0;
            rsp_writable   <= 1'b0;
            rsp_dirty      <= 1'b0;
            rsp_page_fault <= 1'b0;
            rsp_prot_fault <= 1'b0;
        end else if (capture) begin
            rsp_ppn        <= dec_ppn;
            rsp_writable   <= dec_wr;
            rsp_dirty      <= dec_dirty;
            rsp_page_fault <= (dec_outcome == OUT_PAGE_FAULT);
            rsp_prot_fault <= (dec_outcome == OUT_PROT_FAULT);
        end
    end

    // Miss handshake
    always_comb begin
        miss_ready = idle;
    end
endmodule

// File: rtl/pte_walker_checker.sv
// Protocol checker for pte_walker; tracks its own outstanding read and access type.
module pte_walker_checker #(
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_valid,
    input logic             miss_ready,
    input logic             miss_store,
    input logic             mem_req,
    input logic             mem_rvalid,
    input logic             rd_resident,
    input logic             rd_writable,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic             rsp_page_fault,
    input logic             rsp_prot_fault
);
    logic pend_q;
    logic st_q;

    // Outstanding read tracker: set by a request, cleared by returned data
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (mem_req)    pend_q <= 1'b1;
        else if (mem_rvalid) pend_q <= 1'b0;
    end

    // Access type of the accepted miss
    always_ff @(posedge clk) begin
        if (!rst_n)                       st_q <= 1'b0;
        else if (miss_valid && miss_ready) st_q <= miss_store;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (miss_ready && !rsp_valid && !mem_req));

    a_r2_req_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> mem_req);

    a_r10_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r7_resp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && mem_rvalid) |=> rsp_valid);

    a_r5_page_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && mem_rvalid && !rd_resident) |=>
            (rsp_page_fault && !rsp_prot_fault && rsp_ppn == '0));

    a_r6_prot_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && mem_rvalid && rd_resident && !rd_writable && st_q) |=>
            (rsp_prot_fault && !rsp_page_fault && rsp_ppn == '0));

    a_r8_busy_blocks_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req || pend_q) |-> !miss_ready);

    a_r8_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_ppn) && $stable(rsp_page_fault) && $stable(rsp_prot_fault)));
endmodule

bind pte_walker pte_walker_checker #(.PPN_W(PPN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_ready     (miss_ready),
    .miss_store     (miss_store),
    .mem_req        (mem_req),
    .mem_rvalid     (mem_rvalid),
    .rd_resident    (mem_rdata[pwalk_pkg::PTE_RES_BIT]),
    .rd_writable    (mem_rdata[pwalk_pkg::PTE_WR_BIT]),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_ppn        (rsp_ppn),
    .rsp_page_fault (rsp_page_fault),
    .rsp_prot_fault (rsp_prot_fault)
);

// File: tb/pte_walker_test.sv
module pte_walker_test;
    localparam int VPN_W  = 4;
    localparam int PPN_W  = 3;
    localparam int MEM_AW = 6;
    localparam int PTE_W  = PPN_W + 3;
    localparam int DEPTH  = 1 << MEM_AW;

    typedef struct {
        int addr;
        int ppn;
        int wr;
        int dt;
        int pf;
        int prot;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic              miss_ready;
    logic [VPN_W-1:0]  miss_vpn = '0;
    logic              miss_store = 1'b0;
    logic              base_we = 1'b0;
    logic [MEM_AW-1:0] base_wdata = '0;
    logic              mem_req;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [PTE_W-1:0]  mem_rdata = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [PPN_W-1:0]  rsp_ppn;
    logic              rsp_writable, rsp_dirty, rsp_page_fault, rsp_prot_fault;

    logic [PTE_W-1:0] bmem [DEPTH];
    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   model_base = 0;
    int   lat = 1;
    int   stall_n = 0;
    int   last_addr = -1;
    int   last_ppn = 0;
    int   reqs = 0;
    bit   finished = 1'b0;

    pte_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .MEM_AW(MEM_AW)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: present a miss, push expected result once it is accepted
    task automatic walk(input int vpn, input bit st);
        exp_t e;
        logic [PTE_W-1:0] pte;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_vpn   = VPN_W'(vpn);
        miss_store = st;
        while (!miss_ready) @(negedge clk);
        e.addr = (model_base + vpn) % DEPTH;
        pte    = bmem[e.addr];
        e.pf   = !pte[0];
        e.prot = pte[0] && st && !pte[1];
        e.ppn  = (pte[0] && !e.prot) ? int'(pte[5:3]) : 0;
        e.wr   = pte[0] ? int'(pte[1]) : 0;
        e.dt   = pte[0] ? int'(pte[2]) : 0;
        exp_q.push_back(e);
        @(negedge clk);
        miss_valid = 1'b0;
        chk(miss_ready == 1'b0, "R8 busy", int'(miss_ready), 0);
    endtask

    task automatic set_base(input int v, input bit applies);
        @(negedge clk);
        base_we    = 1'b1;
        base_wdata = MEM_AW'(v);
        @(negedge clk);
        base_we = 1'b0;
        if (applies) model_base = v;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(miss_ready && exp_q.size() == 0));
    endtask

    // Memory responder and scoreboard monitor
    int  pend = 0, cnt = 0, cap_addr = 0, stall_cnt = 0;
    bit  hold_prev = 1'b0;
    int  h_ppn = 0, h_pf = 0, h_prot = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rvalid = 1'b0;
            rsp_ready  = 1'b0;
            pend = 0; hold_prev = 1'b0; stall_cnt = 0; reqs = 0;
        end else begin
            if (mem_rvalid) chk(rsp_valid == 1'b1, "R7 response timing", int'(rsp_valid), 1);
            mem_rvalid = 1'b0;
            if (pend != 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = bmem[cap_addr];
                    pend = 0;
                end
            end
            if (mem_req) begin
                pend = 1; cnt = lat; cap_addr = int'(mem_addr);
                last_addr = int'(mem_addr); reqs++;
            end
            if (rsp_valid) begin
                if (hold_prev) begin
                    chk(int'(rsp_ppn) == h_ppn && int'(rsp_page_fault) == h_pf &&
                        int'(rsp_prot_fault) == h_prot, "R8 hold", int'(rsp_ppn), h_ppn);
                end
                if (stall_cnt >= stall_n) begin
                    exp_t e;
                    string tg;
                    rsp_ready = 1'b1;
                    hold_prev = 1'b0;
                    stall_cnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected response", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        tg = e.pf != 0 ? "R5" : (e.prot != 0 ? "R6" : "R4");
                        chk(last_addr == e.addr, "R2 entry address", last_addr, e.addr);
                        chk(reqs == 1, "R10 one read", reqs, 1);
                        chk(int'(rsp_ppn) == e.ppn, tg, int'(rsp_ppn), e.ppn);
                        chk(int'(rsp_page_fault) == e.pf, tg, int'(rsp_page_fault), e.pf);
                        chk(int'(rsp_prot_fault) == e.prot, tg, int'(rsp_prot_fault), e.prot);
                        chk(int'(rsp_writable) == e.wr && int'(rsp_dirty) == e.dt,
                            "R3 flags", {rsp_writable, rsp_dirty}, e.wr * 2 + e.dt);
                        last_ppn = int'(rsp_ppn);
                    end
                    reqs = 0;
                end else begin
                    rsp_ready = 1'b0;
                    hold_prev = 1'b1;
                    stall_cnt++;
                    h_ppn = int'(rsp_ppn); h_pf = int'(rsp_page_fault); h_prot = int'(rsp_prot_fault);
                end
            end else begin
                rsp_ready = 1'b0;
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) bmem[i] = PTE_W'(i * 13 + 5);
        bmem[2]  = 6'b100_011;  // resident, writable, page 4
        bmem[3]  = 6'b110_000;  // not resident, swap slot in field
        bmem[4]  = 6'b011_101;  // resident, read-only, dirty
        bmem[5]  = 6'b111_111;  // resident, writable, dirty, page 7

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(miss_ready == 1'b1, "R1 ready", int'(miss_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp", int'(rsp_valid), 0);
        chk(mem_req == 1'b0, "R1 req", int'(mem_req), 0);

        // R4 worked example: VA 0x2C8 to PA 0x4C8 with base 0
        walk(2, 1'b0);
        wait_idle();
        chk({last_ppn[2:0], 8'hC8} == 11'h4C8, "R4 physical address", {last_ppn[2:0], 8'hC8}, 11'h4C8);

        // R5, R6 corner entries
        walk(3, 1'b1);
        walk(3, 1'b0);
        walk(4, 1'b1);
        walk(4, 1'b0);
        walk(5, 1'b1);
        wait_idle();

        // R7, R8: sweep all pages with varied latency and stalls
        for (int v = 0; v < 16; v++) begin
            lat = 1 + (v % 4);
            stall_n = v % 3;
            walk(v, v[0]);
        end
        wait_idle();

        // R2 wrap and R9 idle write
        set_base(40, 1'b1);
        for (int v = 0; v < 16; v += 5) walk(v, 1'b0);
        wait_idle();
        set_base(60, 1'b1);
        walk(10, 1'b1);
        walk(15, 1'b0);
        wait_idle();

        // R9: write during a long read is ignored
        lat = 6; stall_n = 1;
        walk(7, 1'b0);
        set_base(20, 1'b0);
        wait_idle();
        walk(9, 1'b1);
        wait_idle();
        set_base(20, 1'b1);
        walk(9, 1'b1);
        wait_idle();

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule